// File: doc/BRIEF.md
# SPI FIFO Occupancy, Threshold and Receive Timeout Unit

This block sits between a register-side interface and a serial shift engine. It holds two queues of eight words each. The transmit queue is filled by software and drained by the engine. The receive queue is filled by the engine and drained by software. The block reports the occupancy of each queue as a count plus empty and full flags. It compares each count with a small programmable threshold, each queue using its own rule. It drops received words that arrive while the receive queue is full and raises an overrun flag. It also raises a timeout flag when received data sits unread for too long.

A second state machine raises a go/busy request to the engine. It does so in master mode as soon as transmit data has been queued, and it keeps the request up until the last queued word has been reported done. Its states are GB_IDLE (no request), GB_QUEUED (words wait in the queue) and GB_LAST (the queue is empty and the final word is still being shifted). Its transitions are:
- GB_IDLE to GB_QUEUED on an accepted push in master mode.
- GB_QUEUED to GB_LAST when the last word is popped.
- GB_QUEUED to GB_IDLE on a transmit clear.
- GB_LAST to GB_QUEUED on a new push.
- GB_LAST to GB_IDLE on word-done.

The timeout state machine has three states: TM_IDLE (receive queue empty), TM_COUNT (counting idle time) and TM_EXPIRED (flag raised). Its transitions are:
- TM_IDLE to TM_COUNT when the queue becomes non-empty.
- TM_COUNT restarts itself on any push or pop.
- TM_COUNT to TM_EXPIRED when the limit is reached.
- TM_EXPIRED to TM_COUNT on a pop that leaves data behind.
- Any state to TM_IDLE when the queue becomes empty.

Top module: `spi_fq_unit`

## Requirements
- R1: Each queue holds up to DEPTH (8) words in first-in first-out order. Its count output runs from 0 to 8. Empty is 1 exactly when the count is 0, and full is 1 exactly when the count is 8. The head word is presented on the read data output without a pop.
- R2: A push to a full transmit queue is ignored. The count stays unchanged and the stored words are unchanged.
- R3: An engine word that arrives while the receive queue is full is discarded, and the overrun flag sets one cycle later. A pulse on `ovr_clr` clears the flag, but a new overrun in the same cycle wins and the flag stays 1.
- R4: `rx_thr_sts` is 1 exactly when the receive count is strictly greater than `rx_thr`.
- R5: `tx_thr_sts` is 1 exactly when the transmit count is less than or equal to `tx_thr`.
- R6: A one-cycle pulse on `tx_clr` or `rx_clr` empties that queue at the next edge: count 0, empty 1, full 0. The clear takes priority over a push in the same cycle.
- R7: In slave mode (`cfg_master` = 0), `tmo_flag` rises after 576 clock cycles in which the non-empty receive queue saw neither a push nor a pop. It is still 0 after 575 such cycles.
- R8: In master mode, the idle time is counted in `spi_tick` pulses instead, and the flag rises on the 64th pulse, not the 63rd.
- R9: The idle count restarts from zero on every accepted receive push and every pop. Once the flag is up, only a pop or a receive clear drops it, and a further push leaves it at 1. The flag is never 1 while the receive queue is empty.
- R10: In master mode, an accepted transmit push raises `go_busy` at the next edge. `go_busy` stays 1 while words are queued and while the final popped word is in flight. It falls one edge after `eng_word_done` once the queue is empty. A transmit clear drops it at once. In slave mode, pushes never raise it.
- R11: `irq` is the OR of the four status bits, each masked by its bit in `irq_en`: bit 0 receive threshold, bit 1 transmit threshold, bit 2 overrun, bit 3 timeout.
- R12: After reset both queues are empty with zero counts, and `go_busy`, `ovr_flag` and `tmo_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 = master mode, 0 = slave mode |
| spi_tick | input | 1 | One pulse per serial clock period (master timeout base) |
| irq_en | input | 4 | Interrupt enables: rx threshold, tx threshold, overrun, timeout |
| rx_thr | input | THR_W | Receive threshold |
| tx_thr | input | THR_W | Transmit threshold |
| tx_push | input | 1 | Register-side write into the transmit queue |
| tx_wdata | input | W | Transmit word |
| tx_clr | input | 1 | Empty the transmit queue |
| rx_pop | input | 1 | Register-side read of the receive queue |
| rx_rdata | output | W | Receive queue head word |
| rx_clr | input | 1 | Empty the receive queue |
| ovr_clr | input | 1 | Write-one clear of the overrun flag |
| eng_tx_pop | input | 1 | Engine takes the next transmit word |
| eng_tx_data | output | W | Transmit queue head word |
| eng_word_done | input | 1 | Engine finished shifting a word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | W | Received word |
| go_busy | output | 1 | Transfer request to the engine |
| tx_count | output | CNT_W | Transmit queue count |
| rx_count | output | CNT_W | Receive queue count |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_thr_sts | output | 1 | Receive threshold status |
| tx_thr_sts | output | 1 | Transmit threshold status |
| ovr_flag | output | 1 | Receive overrun flag |
| tmo_flag | output | 1 | Receive timeout flag |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench sweeps every occupancy from 0 to 8 against every threshold value for both queues. A design that swapped the strict and non-strict comparisons would miscompare at the counts equal to the threshold.

The timeout is probed one unit before and exactly at its limit in both modes. This exposes an off-by-one counter, or a counter that counts clocks where it should count serial ticks. Restart and flag-hold cases catch a counter that does not reset on a push, and a flag that a push wrongly clears.

The go/busy checks look at the request after the final pop but before word-done. A design that dropped the request on queue-empty would cut the last word short. The bench also pushes into full queues and checks the simultaneous overrun-and-clear case, so silent overwrites and a clear that wins over a new overrun are both exposed.

// File: rtl/spi_fq_pkg.sv
package spi_fq_pkg;
    typedef enum logic [1:0] {
        GB_IDLE,
        GB_QUEUED,
        GB_LAST
    } gb_state_e;

    typedef enum logic [1:0] {
        TM_IDLE,
        TM_COUNT,
        TM_EXPIRED
    } tm_state_e;

    localparam int IRQ_RXTHR = 0;
    localparam int IRQ_TXTHR = 1;
    localparam int IRQ_OVR   = 2;
    localparam int IRQ_TMO   = 3;
    localparam int IRQ_N     = 4;
endpackage

// File: rtl/spi_fq_fifo.sv
module spi_fq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full,
    output logic             push_ok,
    output logic             pop_ok
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // R1: occupancy flags come straight from the registered count
    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end
endmodule

// File: rtl/spi_fq_rx_timer.sv
module spi_fq_rx_timer
    import spi_fq_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int TMO_MASTER = 64,
    parameter int TMO_SLAVE  = 576,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int TMO_MAX = (TMO_MASTER > TMO_SLAVE) ? TMO_MASTER : TMO_SLAVE,
    localparam int TMR_W = $clog2(TMO_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master,
    input  logic             tick,
    input  logic             clr,
    input  logic             push_ok,
    input  logic             pop_ok,
    input  logic [CNT_W-1:0] count,
    output logic             expired
);
    tm_state_e        state, state_nx;
    logic [TMR_W-1:0] tmr, tmr_nx;
    logic             step;
    logic [TMR_W-1:0] last;
    logic             goes_empty;

    assign step = master ? tick : 1'b1;
    assign last = master ? TMR_W'(TMO_MASTER - 1) : TMR_W'(TMO_SLAVE - 1);
    assign goes_empty = clr
                     || (count == '0 && !push_ok)
                     || (count == CNT_W'(1) && pop_ok && !push_ok);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TM_IDLE;
            tmr   <= '0;
        end else begin
            state <= state_nx;
            tmr   <= tmr_nx;
        end
    end

    always_comb begin
        state_nx = state;
        tmr_nx   = tmr;
        unique case (state)
            TM_IDLE: begin
                tmr_nx = '0;
                if (!goes_empty) state_nx = TM_COUNT;
            end
            TM_COUNT: begin
                if (goes_empty) begin
                    state_nx = TM_IDLE;
                    tmr_nx   = '0;
                end else if (push_ok || pop_ok) begin
                    tmr_nx = '0;                  // R9 restart
                end else if (step && tmr >= last) begin
                    state_nx = TM_EXPIRED;        // R7 / R8
                    tmr_nx   = '0;
                end else if (step) begin
                    tmr_nx = tmr + 1'b1;
                end
            end
            TM_EXPIRED: begin
                if (goes_empty) begin
                    state_nx = TM_IDLE;
                end else if (pop_ok) begin
                    state_nx = TM_COUNT;          // R9 read clears flag
                    tmr_nx   = '0;
                end
            end
            default: state_nx = TM_IDLE;
        endcase
    end

    always_comb expired = (state == TM_EXPIRED);
endmodule

// File: rtl/spi_fq_gobusy.sv
module spi_fq_gobusy
    import spi_fq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master,
    input  logic             clr,
    input  logic             push_ok,
    input  logic             pop_ok,
    input  logic [CNT_W-1:0] count,
    input  logic             word_done,
    output logic             go_busy
);
    gb_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GB_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            GB_IDLE:
                if (master && push_ok) state_nx = GB_QUEUED;
            GB_QUEUED:
                if (clr) state_nx = GB_IDLE;
                else if (pop_ok && !push_ok && count == CNT_W'(1)) state_nx = GB_LAST;
            GB_LAST:
                if (push_ok) state_nx = GB_QUEUED;
                else if (word_done || clr) state_nx = GB_IDLE;
            default: state_nx = GB_IDLE;
        endcase
    end

    always_comb go_busy = (state != GB_IDLE);
endmodule

// File: rtl/spi_fq_unit.sv
module spi_fq_unit
    import spi_fq_pkg::*;
#(
    parameter int W          = 32,
    parameter int DEPTH      = 8,
    parameter int THR_W      = 2,
    parameter int TMO_MASTER = 64,
    parameter int TMO_SLAVE  = 576,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_master,
    input  logic             spi_tick,
    input  logic [IRQ_N-1:0] irq_en,
    input  logic [THR_W-1:0] rx_thr,
    input  logic [THR_W-1:0] tx_thr,
    input  logic             tx_push,
    input  logic [W-1:0]     tx_wdata,
    input  logic             tx_clr,
    input  logic             rx_pop,
    output logic [W-1:0]     rx_rdata,
    input  logic             rx_clr,
    input  logic             ovr_clr,
    input  logic             eng_tx_pop,
    output logic [W-1:0]     eng_tx_data,
    input  logic             eng_word_done,
    input  logic             eng_rx_push,
    input  logic [W-1:0]     eng_rx_data,
    output logic             go_busy,
    output logic [CNT_W-1:0] tx_count,
    output logic [CNT_W-1:0] rx_count,
    output logic             tx_empty,
    output logic             tx_full,
    output logic             rx_empty,
    output logic             rx_full,
    output logic             rx_thr_sts,
    output logic             tx_thr_sts,
    output logic             ovr_flag,
    output logic             tmo_flag,
    output logic             irq
);
    logic tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic [IRQ_N-1:0] sts;

    spi_fq_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_push), .wdata(tx_wdata), .pop(eng_tx_pop),
        .head(eng_tx_data), .count(tx_count), .empty(tx_empty), .full(tx_full),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
    );

    spi_fq_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(eng_rx_push), .wdata(eng_rx_data), .pop(rx_pop),
        .head(rx_rdata), .count(rx_count), .empty(rx_empty), .full(rx_full),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
    );

    spi_fq_rx_timer #(.DEPTH(DEPTH), .TMO_MASTER(TMO_MASTER), .TMO_SLAVE(TMO_SLAVE)) u_tmr (
        .clk(clk), .rst_n(rst_n), .master(cfg_master), .tick(spi_tick),
        .clr(rx_clr), .push_ok(rx_push_ok), .pop_ok(rx_pop_ok),
        .count(rx_count), .expired(tmo_flag)
    );

    spi_fq_gobusy #(.DEPTH(DEPTH)) u_gb (
        .clk(clk), .rst_n(rst_n), .master(cfg_master), .clr(tx_clr),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok), .count(tx_count),
        .word_done(eng_word_done), .go_busy(go_busy)
    );

    // R3: overrun set has priority over the write-one clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              ovr_flag <= 1'b0;
        else if (eng_rx_push && rx_full && !rx_clr) ovr_flag <= 1'b1;
        else if (ovr_clr)                        ovr_flag <= 1'b0;
    end

    // R4 strict-greater, R5 less-or-equal
    assign rx_thr_sts = rx_count >  {{(CNT_W-THR_W){1'b0}}, rx_thr};
    assign tx_thr_sts = tx_count <= {{(CNT_W-THR_W){1'b0}}, tx_thr};

    always_comb begin
        sts            = '0;
        sts[IRQ_RXTHR] = rx_thr_sts;
        sts[IRQ_TXTHR] = tx_thr_sts;
        sts[IRQ_OVR]   = ovr_flag;
        sts[IRQ_TMO]   = tmo_flag;
    end

    assign irq = |(sts & irq_en);   // R11
endmodule

// File: rtl/spi_fq_checker.sv
module spi_fq_checker #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_master,
    input logic             tx_push,
    input logic             tx_clr,
    input logic             rx_pop,
    input logic             rx_clr,
    input logic             eng_tx_pop,
    input logic             eng_rx_push,
    input logic             go_busy,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count,
    input logic             tx_empty,
    input logic             tx_full,
    input logic             rx_empty,
    input logic             rx_full,
    input logic             ovr_flag,
    input logic             tmo_flag
);
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CNT_W'(DEPTH) && rx_count <= CNT_W'(DEPTH));

    p_full_push_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full && tx_push && !eng_tx_pop && !tx_clr |=> tx_count == $past(tx_count));

    p_ovr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && eng_rx_push && !rx_clr |=> ovr_flag && rx_full);

    p_clr_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr |=> tx_empty && !tx_full);

    p_tmo_needs_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> !tmo_flag);

    p_pop_clears_tmo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop && !rx_empty |=> !tmo_flag);

    p_gb_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_master && tx_push && !tx_full && !tx_clr |=> go_busy);

    p_gb_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(go_busy) |-> tx_empty);
endmodule

bind spi_fq_unit spi_fq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
    .tx_push(tx_push), .tx_clr(tx_clr), .rx_pop(rx_pop), .rx_clr(rx_clr),
    .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push), .go_busy(go_busy),
    .tx_count(tx_count), .rx_count(rx_count), .tx_empty(tx_empty), .tx_full(tx_full),
    .rx_empty(rx_empty), .rx_full(rx_full), .ovr_flag(ovr_flag), .tmo_flag(tmo_flag)
);

// File: tb/spi_fq_unit_tb_top.sv
module spi_fq_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_master = 1'b1, spi_tick = 1'b0;
    logic [3:0] irq_en = '0;
    logic [1:0] rx_thr = '0, tx_thr = '0;
    logic tx_push = 0, tx_clr = 0, rx_pop = 0, rx_clr = 0, ovr_clr = 0;
    logic eng_tx_pop = 0, eng_word_done = 0, eng_rx_push = 0;
    logic [W-1:0] tx_wdata = '0, eng_rx_data = '0;
    logic [W-1:0] rx_rdata, eng_tx_data;
    logic go_busy, tx_empty, tx_full, rx_empty, rx_full;
    logic rx_thr_sts, tx_thr_sts, ovr_flag, tmo_flag, irq;
    logic [3:0] tx_count, rx_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_fq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .spi_tick(spi_tick),
        .irq_en(irq_en), .rx_thr(rx_thr), .tx_thr(tx_thr),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_clr(tx_clr),
        .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_clr(rx_clr), .ovr_clr(ovr_clr),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_word_done(eng_word_done),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .go_busy(go_busy), .tx_count(tx_count), .rx_count(rx_count),
        .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
        .rx_thr_sts(rx_thr_sts), .tx_thr_sts(tx_thr_sts),
        .ovr_flag(ovr_flag), .tmo_flag(tmo_flag), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic push_tx(input logic [W-1:0] d);
        tx_push = 1; tx_wdata = d; cyc(); tx_push = 0;
    endtask

    task automatic push_rx(input logic [W-1:0] d);
        eng_rx_push = 1; eng_rx_data = d; cyc(); eng_rx_push = 0;
    endtask

    task automatic stick();
        spi_tick = 1; cyc(); spi_tick = 0; cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        #(CLK_PERIOD*2 + 1);
        rst_n = 1'b1;
        cyc();
        // R12 reset state
        check("R12 tx_count", tx_count, 0);
        check("R12 rx_count", rx_count, 0);
        check("R12 empties", {tx_empty, rx_empty}, 2'b11);
        check("R12 flags", {go_busy, ovr_flag, tmo_flag}, 3'b000);

        // R1 / R5 sweep of transmit occupancy against thresholds, R10 start
        for (int k = 0; k <= DEPTH; k++) begin
            for (int t = 0; t < 4; t++) begin
                tx_thr = 2'(t); #1;
                check("R5 tx_thr_sts", tx_thr_sts, (k <= t));
            end
            check("R1 tx_count", tx_count, k);
            check("R1 tx_empty", tx_empty, (k == 0));
            check("R1 tx_full", tx_full, (k == DEPTH));
            if (k == 1) check("R10 go_busy after push", go_busy, 1);
            if (k < DEPTH) push_tx(32'hC0DE_0000 + k);
        end
        // R2 push into full queue is ignored
        push_tx(32'hDEAD_BEEF);
        check("R2 count held", tx_count, DEPTH);
        // R1 order on drain, R10 held through last word
        for (int i = 0; i < DEPTH; i++) begin
            check("R1 tx order", eng_tx_data, 32'hC0DE_0000 + i);
            eng_tx_pop = 1; cyc(); eng_tx_pop = 0;
        end
        check("R2 overflow word absent", tx_empty, 1);
        check("R10 busy while last in flight", go_busy, 1);
        eng_word_done = 1; cyc(); eng_word_done = 0;
        check("R10 busy falls on done", go_busy, 0);

        // R6 / R10 transmit clear from full
        for (int i = 0; i < DEPTH; i++) push_tx(i);
        check("R10 busy queued", go_busy, 1);
        tx_clr = 1; tx_push = 1; cyc(); tx_clr = 0; tx_push = 0;
        check("R6 tx cleared", {tx_empty, tx_full, tx_count}, {2'b10, 4'd0});
        check("R10 busy dropped by clear", go_busy, 0);

        // R4 sweep of receive occupancy
        for (int k = 0; k <= DEPTH; k++) begin
            for (int t = 0; t < 4; t++) begin
                rx_thr = 2'(t); #1;
                check("R4 rx_thr_sts", rx_thr_sts, (k > t));
            end
            check("R1 rx_count", rx_count, k);
            check("R1 rx_full", rx_full, (k == DEPTH));
            if (k < DEPTH) push_rx(32'h5A00_0000 + k);
        end
        // R3 overrun
        check("R3 no overrun yet", ovr_flag, 0);
        push_rx(32'hBAD0_0000);
        check("R3 count held", rx_count, DEPTH);
        check("R3 overrun set", ovr_flag, 1);
        // R11 masking
        irq_en = 4'b0100; #1; check("R11 ovr irq", irq, 1);
        irq_en = 4'b1000; #1; check("R11 tmo masked off", irq, 0);
        irq_en = 4'b0000; #1; check("R11 all masked", irq, 0);
        irq_en = 4'b0001; #1; check("R11 rx thr irq", irq, 1);
        irq_en = 4'b0000;
        // R3 set beats clear
        ovr_clr = 1; push_rx(32'hBAD0_0001); ovr_clr = 0;
        check("R3 set wins", ovr_flag, 1);
        ovr_clr = 1; cyc(); ovr_clr = 0;
        check("R3 cleared", ovr_flag, 0);
        // R1 receive order
        for (int i = 0; i < DEPTH; i++) begin
            check("R1 rx order", rx_rdata, 32'h5A00_0000 + i);
            rx_pop = 1; cyc(); rx_pop = 0;
        end
        check("R1 rx drained", rx_empty, 1);

        // R8 master timeout
        rx_thr = 2'd3;
        push_rx(32'h1);
        for (int i = 0; i < 63; i++) stick();
        check("R8 before limit", tmo_flag, 0);
        stick();
        check("R8 at limit", tmo_flag, 1);
        irq_en = 4'b1000; #1; check("R11 tmo irq", irq, 1); irq_en = 0;
        // R9 push holds flag, pop clears
        push_rx(32'h2);
        check("R9 push keeps flag", tmo_flag, 1);
        rx_pop = 1; cyc(); rx_pop = 0;
        check("R9 pop clears", tmo_flag, 0);
        // R9 restart on push
        for (int i = 0; i < 40; i++) stick();
        push_rx(32'h3);
        for (int i = 0; i < 63; i++) stick();
        check("R9 restarted by push", tmo_flag, 0);
        stick();
        check("R9 expires after restart", tmo_flag, 1);
        // R6 receive clear
        rx_clr = 1; cyc(); rx_clr = 0;
        check("R6 rx cleared", {rx_empty, rx_full, rx_count}, {2'b10, 4'd0});
        check("R6 tmo dropped", tmo_flag, 0);

        // R7 slave timeout counts clocks, ignores ticks
        cfg_master = 0;
        push_rx(32'h4);
        repeat (575) cyc();
        check("R7 before limit", tmo_flag, 0);
        cyc();
        check("R7 at limit", tmo_flag, 1);
        rx_clr = 1; cyc(); rx_clr = 0;

        // R10 slave push does not raise request
        push_tx(32'h77);
        check("R10 slave no busy", go_busy, 0);
        check("R1 slave push stored", tx_count, 1);
        tx_clr = 1; cyc(); tx_clr = 0;

        finish_run();
    end
endmodule